// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block is the register-side interrupt logic of a DMA-driven network controller. It holds a DMA status register whose event bits are set by single-cycle hardware event pulses and cleared by software writing ones. It also holds an interrupt enable register, a bus mode register with a self-clearing software reset bit, a MAC configuration register, two descriptor base address registers and two current-descriptor registers. Two sticky summary bits, one per event class, collect the enabled events. A single level-sensitive interrupt line follows the enabled summaries.

Software reaches the registers through a 32-bit interface. A write is a one-cycle strobe with address and data. A read is a one-cycle request whose data appears on the following cycle and is held until the next read. Addresses are byte addresses, and only the exact word-aligned offsets listed below decode. When transmit or receive is switched on in the MAC configuration register, the matching current-descriptor register is loaded from its base address register, so that a DMA engine can start fetching from there.

Register offsets: 0x00 status, 0x04 interrupt enable, 0x08 bus mode, 0x0C MAC configuration, 0x10 transmit descriptor base, 0x14 receive descriptor base, 0x18 current transmit descriptor, 0x1C current receive descriptor, 0x20 transmit poll demand, 0x24 receive poll demand.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A read request at a decoded offset returns that register's value on `rd_data` one cycle later. A read of any other address (unmapped or not word aligned) returns zero. After reset, status, interrupt enable, MAC configuration, both base addresses and both current descriptors read 0, and bus mode reads its reset value (default 0x0000_0100).
- R2: The normal-class event bits are status bits 0, 2 and 6. The abnormal-class event bits are bits 1, 3, 4, 5, 7, 8, 9, 10 and 13. A high `evt_i` bit at one of these positions sets that status bit, which is visible from the next cycle. Writing one to an event bit clears it. Writing zero leaves it unchanged. `evt_i` bits at any other position have no effect.
- R3: When a hardware event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R4: A status write with any of bits 31 to 17 set is discarded completely. No bit is cleared.
- R5: The normal summary (status bit 16) is set when a normal-class event bit and its enable bit are both one. It stays set until a status write puts a one on bit 16 or on any normal-class bit. In the same cycle it is re-evaluated from the event and enable bits that remain.
- R6: The abnormal summary (status bit 15) follows the rule of R5 for the abnormal class. It is not cleared by writing normal-class bits.
- R7: `irq_o` is high exactly when (status bit 16 and enable bit 16) or (status bit 15 and enable bit 15) are both set. It reflects a register write or event from the next cycle on.
- R8: A bus mode write with bit 0 set reloads every register with its reset value in the next cycle. Bit 0 then reads zero, `irq_o` drops, and events arriving in that cycle are dropped.
- R9: A MAC configuration write that takes bit 3 (transmit enable) from 0 to 1 copies the transmit descriptor base into the current transmit descriptor. A write that leaves bit 3 at one does not copy it again.
- R10: A MAC configuration write that takes bit 2 (receive enable) from 0 to 1 copies the receive descriptor base into the current receive descriptor. It does not touch the transmit side.
- R11: Writes to the two poll-demand offsets store nothing, and reads of them return zero. Writes to the current-descriptor registers are ignored. Status bits 11, 12, 14 and 31 to 17 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | AW (8) | Write byte address |
| wr_data | input | DW (32) | Write data |
| rd_en | input | 1 | Single-cycle read request |
| rd_addr | input | AW (8) | Read byte address |
| rd_data | output | DW (32) | Read data, valid the cycle after `rd_en` |
| evt_i | input | DW (32) | Hardware event pulses, one bit per status position |
| irq_o | output | 1 | Level-sensitive interrupt |

## Verification
The assertions assume that there is at most one register write per cycle, carried by one strobe. They also assume that reset is held across the first clock edge. The rejected-write property applies only in cycles without an event pulse, because an event may still set a bit while a write is discarded. The bench drives all inputs on falling clock edges. It never pulses an event in the same cycle as a soft reset, issues reads only in cycles with no write, and uses a deliberate event-plus-clear overlap only in the set-priority scenario.

// File: rtl/dmaisc_pkg.sv
package dmaisc_pkg;

   // Byte offsets of the register map (word aligned only)
   localparam logic [31:0] OFS_STATUS  = 32'h00;
   localparam logic [31:0] OFS_IEN     = 32'h04;
   localparam logic [31:0] OFS_BUSMODE = 32'h08;
   localparam logic [31:0] OFS_MACCFG  = 32'h0C;
   localparam logic [31:0] OFS_TXBASE  = 32'h10;
   localparam logic [31:0] OFS_RXBASE  = 32'h14;
   localparam logic [31:0] OFS_CURTX   = 32'h18;
   localparam logic [31:0] OFS_CURRX   = 32'h1C;
   localparam logic [31:0] OFS_TXPOLL  = 32'h20;
   localparam logic [31:0] OFS_RXPOLL  = 32'h24;

   typedef struct packed {
      logic status;
      logic ien;
      logic busmode;
      logic maccfg;
      logic txbase;
      logic rxbase;
      logic curtx;
      logic currx;
      logic txpoll;
      logic rxpoll;
   } regsel_t;

   function automatic regsel_t decode_addr(input logic [31:0] a);
      regsel_t s;
      s.status  = (a == OFS_STATUS);
      s.ien     = (a == OFS_IEN);
      s.busmode = (a == OFS_BUSMODE);
      s.maccfg  = (a == OFS_MACCFG);
      s.txbase  = (a == OFS_TXBASE);
      s.rxbase  = (a == OFS_RXBASE);
      s.curtx   = (a == OFS_CURTX);
      s.currx   = (a == OFS_CURRX);
      s.txpoll  = (a == OFS_TXPOLL);
      s.rxpoll  = (a == OFS_RXPOLL);
      return s;
   endfunction

endpackage

// File: rtl/dmaisc_cfg.sv
module dmaisc_cfg #(
   parameter int unsigned     DW       = 32,
   parameter logic [DW-1:0]   BUS_RST  = 'h100,
   parameter int unsigned     TXEN_BIT = 3,
   parameter int unsigned     RXEN_BIT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ien,
   input  logic          wr_bus,
   input  logic          wr_mac,
   input  logic          wr_txb,
   input  logic          wr_rxb,
   input  logic [DW-1:0] wr_data,
   output logic          swrst,
   output logic [DW-1:0] ien_nxt,
   output logic [DW-1:0] ien_q,
   output logic [DW-1:0] busmode_q,
   output logic [DW-1:0] maccfg_q,
   output logic [DW-1:0] txbase_q,
   output logic [DW-1:0] rxbase_q,
   output logic [DW-1:0] curtx_q,
   output logic [DW-1:0] currx_q
);

   logic tx_rise;
   logic rx_rise;

   // Soft reset: bus mode write with bit 0 set
   assign swrst   = wr_bus & wr_data[0];
   // Enable edges are taken against the stored configuration
   assign tx_rise = wr_mac & wr_data[TXEN_BIT] & ~maccfg_q[TXEN_BIT];
   assign rx_rise = wr_mac & wr_data[RXEN_BIT] & ~maccfg_q[RXEN_BIT];

   // Enable value that will hold after this edge, used by the summary logic
   always_comb begin
      if (swrst)       ien_nxt = '0;
      else if (wr_ien) ien_nxt = wr_data;
      else             ien_nxt = ien_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q     <= '0;
         busmode_q <= BUS_RST;
         maccfg_q  <= '0;
         txbase_q  <= '0;
         rxbase_q  <= '0;
         curtx_q   <= '0;
         currx_q   <= '0;
      end else if (swrst) begin
         ien_q     <= '0;
         busmode_q <= BUS_RST;
         maccfg_q  <= '0;
         txbase_q  <= '0;
         rxbase_q  <= '0;
         curtx_q   <= '0;
         currx_q   <= '0;
      end else begin
         ien_q <= ien_nxt;
         if (wr_bus) busmode_q <= wr_data;
         if (wr_mac) maccfg_q  <= wr_data;
         if (wr_txb) txbase_q  <= wr_data;
         if (wr_rxb) rxbase_q  <= wr_data;
         if (tx_rise) curtx_q  <= txbase_q;
         if (rx_rise) currx_q  <= rxbase_q;
      end
   end

   AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rise && !swrst) |=> (curtx_q == $past(txbase_q)))
      else $error("current tx descriptor not loaded"); // R9

   AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rise && !swrst) |=> (currx_q == $past(rxbase_q)))
      else $error("current rx descriptor not loaded"); // R10

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_rise && !swrst) |=> $stable(curtx_q))
      else $error("current tx descriptor moved without enable edge"); // R9

   AST_SWRST_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      swrst |=> (busmode_q == BUS_RST && ien_q == '0 && curtx_q == '0))
      else $error("soft reset did not reload configuration"); // R8

endmodule

// File: rtl/dmaisc_status.sv
module dmaisc_status #(
   parameter int unsigned   DW        = 32,
   parameter logic [DW-1:0] NORM_MASK = 'h45,
   parameter logic [DW-1:0] ABN_MASK  = 'h27BA,
   parameter int unsigned   NSUM_BIT  = 16,
   parameter int unsigned   ASUM_BIT  = 15,
   parameter int unsigned   RO_LSB    = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          swrst,
   input  logic          wr_stat,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] evt_i,
   input  logic [DW-1:0] ien_nxt,
   input  logic          nsum_en,
   input  logic          asum_en,
   output logic [DW-1:0] status_q,
   output logic          irq_o
);

   localparam logic [DW-1:0] EVT_MASK = NORM_MASK | ABN_MASK;
   localparam logic [DW-1:0] RO_MASK  = {DW{1'b1}} << RO_LSB;

   logic [DW-1:0] evt_in;
   logic [DW-1:0] evt_nxt;
   logic [DW-1:0] evt_q;
   logic          accept;
   logic          clr_n;
   logic          clr_a;
   logic          sum_n_q;
   logic          sum_a_q;
   logic          sum_n_nxt;
   logic          sum_a_nxt;

   assign evt_in = evt_i & EVT_MASK;
   // Any read-only bit in the write data voids the whole write
   assign accept = wr_stat & ((wr_data & RO_MASK) == '0);

   // One write-one-to-clear cell per event position, constant zero elsewhere
   for (genvar g = 0; g < DW; g++) begin : g_cell
      if (EVT_MASK[g]) begin : g_evt
         assign evt_nxt[g] = evt_in[g] | (evt_q[g] & ~(accept & wr_data[g]));
      end else begin : g_none
         assign evt_nxt[g] = 1'b0;
      end
   end

   assign clr_n = accept & (((wr_data & NORM_MASK) != '0) | wr_data[NSUM_BIT]);
   assign clr_a = accept & (((wr_data & ABN_MASK)  != '0) | wr_data[ASUM_BIT]);

   // Sticky summaries, re-evaluated from the post-edge event and enable bits
   assign sum_n_nxt = (sum_n_q & ~clr_n) | ((evt_nxt & ien_nxt & NORM_MASK) != '0);
   assign sum_a_nxt = (sum_a_q & ~clr_a) | ((evt_nxt & ien_nxt & ABN_MASK)  != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q   <= '0;
         sum_n_q <= 1'b0;
         sum_a_q <= 1'b0;
      end else if (swrst) begin
         evt_q   <= '0;
         sum_n_q <= 1'b0;
         sum_a_q <= 1'b0;
      end else begin
         evt_q   <= evt_nxt;
         sum_n_q <= sum_n_nxt;
         sum_a_q <= sum_a_nxt;
      end
   end

   always_comb begin
      status_q           = evt_q;
      status_q[NSUM_BIT] = sum_n_q;
      status_q[ASUM_BIT] = sum_a_q;
   end

   assign irq_o = (sum_n_q & nsum_en) | (sum_a_q & asum_en);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!swrst && evt_in != '0) |=> ((evt_q & $past(evt_in)) == $past(evt_in)))
      else $error("event lost against clear"); // R3

   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !swrst) |=> ((evt_q & $past(wr_data & EVT_MASK & ~evt_in)) == '0))
      else $error("written-one event bit survived"); // R2

   AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (wr_data & RO_MASK) != '0 && !swrst && evt_in == '0) |=> $stable(status_q))
      else $error("rejected status write changed status"); // R4

   AST_SWRST_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      swrst |=> (status_q == '0 && !irq_o))
      else $error("soft reset left status or irq"); // R8

   AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (status_q[NSUM_BIT] || status_q[ASUM_BIT]))
      else $error("irq without summary"); // R7

endmodule

// File: rtl/dmaisc_rdmux.sv
module dmaisc_rdmux #(
   parameter int unsigned DW = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  dmaisc_pkg::regsel_t rd_sel,
   input  logic [DW-1:0]       status_q,
   input  logic [DW-1:0]       ien_q,
   input  logic [DW-1:0]       busmode_q,
   input  logic [DW-1:0]       maccfg_q,
   input  logic [DW-1:0]       txbase_q,
   input  logic [DW-1:0]       rxbase_q,
   input  logic [DW-1:0]       curtx_q,
   input  logic [DW-1:0]       currx_q,
   output logic [DW-1:0]       rd_data
);

   logic [DW-1:0] mux;
   logic          hit;

   assign hit = (rd_sel != '0);

   // Poll-demand offsets decode but select nothing, so they read zero
   always_comb begin
      mux = '0;
      if (rd_sel.status)  mux = status_q;
      if (rd_sel.ien)     mux = ien_q;
      if (rd_sel.busmode) mux = busmode_q;
      if (rd_sel.maccfg)  mux = maccfg_q;
      if (rd_sel.txbase)  mux = txbase_q;
      if (rd_sel.rxbase)  mux = rxbase_q;
      if (rd_sel.curtx)   mux = curtx_q;
      if (rd_sel.currx)   mux = currx_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= hit ? mux : '0;
   end

   AST_POLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_sel.txpoll || rd_sel.rxpoll)) |=> (rd_data == '0))
      else $error("poll-demand read not zero"); // R11

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data))
      else $error("read data moved without request"); // R1

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
   parameter int unsigned   DW        = 32,
   parameter int unsigned   AW        = 8,
   parameter logic [DW-1:0] NORM_MASK = 'h0000_0045,
   parameter logic [DW-1:0] ABN_MASK  = 'h0000_27BA,
   parameter int unsigned   NSUM_BIT  = 16,
   parameter int unsigned   ASUM_BIT  = 15,
   parameter int unsigned   RO_LSB    = 17,
   parameter int unsigned   TXEN_BIT  = 3,
   parameter int unsigned   RXEN_BIT  = 2,
   parameter logic [DW-1:0] BUS_RST   = 'h0000_0100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic [DW-1:0] evt_i,
   output logic          irq_o
);
   import dmaisc_pkg::*;

   localparam logic [DW-1:0] SUM_MASK = (DW'(1) << NSUM_BIT) | (DW'(1) << ASUM_BIT);

   // Elaboration-time parameter checks
   if (AW < 6 || AW > 32) begin : g_bad_aw
      $error("AW must be 6..32");
   end
   if (DW <= RO_LSB || DW > 32) begin : g_bad_dw
      $error("DW must exceed RO_LSB and be at most 32");
   end
   if ((NORM_MASK & ABN_MASK) != '0) begin : g_bad_cls
      $error("event classes overlap");
   end
   if (((NORM_MASK | ABN_MASK) & SUM_MASK) != '0 || NSUM_BIT == ASUM_BIT) begin : g_bad_sum
      $error("summary bits collide");
   end
   if (NSUM_BIT >= RO_LSB || ASUM_BIT >= RO_LSB ||
       ((NORM_MASK | ABN_MASK) >> RO_LSB) != '0) begin : g_bad_ro
      $error("status bits reach the read-only field");
   end
   if (TXEN_BIT == RXEN_BIT || BUS_RST[0]) begin : g_bad_cfg
      $error("bad enable positions or bus mode reset value");
   end

   logic [31:0]   wa;
   logic          wr_stat, wr_ien, wr_bus, wr_mac, wr_txb, wr_rxb;
   logic          swrst;
   regsel_t       rd_sel;
   logic [DW-1:0] ien_nxt, ien_q, busmode_q, maccfg_q;
   logic [DW-1:0] txbase_q, rxbase_q, curtx_q, currx_q, status_q;

   assign wa      = 32'(wr_addr);
   assign wr_stat = wr_en & (wa == OFS_STATUS);
   assign wr_ien  = wr_en & (wa == OFS_IEN);
   assign wr_bus  = wr_en & (wa == OFS_BUSMODE);
   assign wr_mac  = wr_en & (wa == OFS_MACCFG);
   assign wr_txb  = wr_en & (wa == OFS_TXBASE);
   assign wr_rxb  = wr_en & (wa == OFS_RXBASE);
   assign rd_sel  = decode_addr(32'(rd_addr));

   dmaisc_cfg #(
      .DW(DW), .BUS_RST(BUS_RST), .TXEN_BIT(TXEN_BIT), .RXEN_BIT(RXEN_BIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_ien(wr_ien), .wr_bus(wr_bus), .wr_mac(wr_mac),
      .wr_txb(wr_txb), .wr_rxb(wr_rxb), .wr_data(wr_data),
      .swrst(swrst), .ien_nxt(ien_nxt), .ien_q(ien_q),
      .busmode_q(busmode_q), .maccfg_q(maccfg_q),
      .txbase_q(txbase_q), .rxbase_q(rxbase_q),
      .curtx_q(curtx_q), .currx_q(currx_q)
   );

   dmaisc_status #(
      .DW(DW), .NORM_MASK(NORM_MASK), .ABN_MASK(ABN_MASK),
      .NSUM_BIT(NSUM_BIT), .ASUM_BIT(ASUM_BIT), .RO_LSB(RO_LSB)
   ) u_status (
      .clk(clk), .rst_n(rst_n), .swrst(swrst),
      .wr_stat(wr_stat), .wr_data(wr_data), .evt_i(evt_i),
      .ien_nxt(ien_nxt), .nsum_en(ien_q[NSUM_BIT]), .asum_en(ien_q[ASUM_BIT]),
      .status_q(status_q), .irq_o(irq_o)
   );

   dmaisc_rdmux #(.DW(DW)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
      .status_q(status_q), .ien_q(ien_q), .busmode_q(busmode_q),
      .maccfg_q(maccfg_q), .txbase_q(txbase_q), .rxbase_q(rxbase_q),
      .curtx_q(curtx_q), .currx_q(currx_q), .rd_data(rd_data)
   );

   AST_BUS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bus |=> (busmode_q[0] == 1'b0))
      else $error("bus mode reset bit did not self-clear"); // R8

endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;

   localparam logic [7:0] A_STAT = 8'h00, A_IEN = 8'h04, A_BUS = 8'h08,
                          A_MAC = 8'h0C, A_TXB = 8'h10, A_RXB = 8'h14,
                          A_CTX = 8'h18, A_CRX = 8'h1C, A_TXP = 8'h20,
                          A_RXP = 8'h24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] evt_i = '0;
   logic        irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dma_irq_ctrl u_dma_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .evt_i(evt_i), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [31:0] e);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; evt_i = e;
      @(negedge clk); wr_en = 1'b0; evt_i = '0;
   endtask

   task automatic pulse(input logic [31:0] e);
      @(negedge clk); evt_i = e;
      @(negedge clk); evt_i = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; rd_addr = a;
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset;
      chk_rd("R1 status after reset", A_STAT, 32'h0);
      chk_rd("R1 ien after reset", A_IEN, 32'h0);
      chk_rd("R1 busmode after reset", A_BUS, 32'h100);
      chk_rd("R1 unmapped read", 8'h40, 32'h0);
      chk_rd("R1 misaligned read", 8'h09, 32'h0);
      chk("R7 irq after reset", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_w1c;
      pulse(32'h0000_0009);
      chk_rd("R2 events set", A_STAT, 32'h9);
      wr(A_STAT, 32'h1);
      chk_rd("R2 one clears", A_STAT, 32'h8);
      wr(A_STAT, 32'h0);
      chk_rd("R2 zero keeps", A_STAT, 32'h8);
      wr(A_STAT, 32'h8);
      chk_rd("R2 cleared", A_STAT, 32'h0);
      pulse(32'h0000_5800);   // bits 11, 12, 14 are not events
      chk_rd("R11 non-event bits read zero", A_STAT, 32'h0);
   endtask

   task automatic t_reject;
      pulse(32'h5);
      wr(A_STAT, 32'h0002_0005);
      chk_rd("R4 write with RO bit discarded", A_STAT, 32'h5);
      wr(A_STAT, 32'h8000_0001);
      chk_rd("R4 write with bit 31 discarded", A_STAT, 32'h5);
      wr(A_STAT, 32'h5);
      chk_rd("R4 legal write clears", A_STAT, 32'h0);
   endtask

   task automatic t_normal;
      wr(A_IEN, 32'h0001_0001);
      pulse(32'h1);
      chk_rd("R5 normal summary set", A_STAT, 32'h0001_0001);
      chk("R7 irq from normal summary", {31'b0, irq_o}, 32'h1);
      pulse(32'h4);
      chk_rd("R5 unenabled event added", A_STAT, 32'h0001_0005);
      wr(A_STAT, 32'h4);
      chk_rd("R5 summary re-evaluated after member clear", A_STAT, 32'h0001_0001);
      chk("R7 irq stays", {31'b0, irq_o}, 32'h1);
      wr(A_STAT, 32'h1);
      chk_rd("R5 summary cleared with last member", A_STAT, 32'h0);
      chk("R7 irq drops", {31'b0, irq_o}, 32'h0);
      // stickiness after the event enable is removed
      pulse(32'h1);
      wr(A_IEN, 32'h0001_0000);
      chk_rd("R5 summary sticky", A_STAT, 32'h0001_0001);
      chk("R7 irq sticky", {31'b0, irq_o}, 32'h1);
      wr(A_STAT, 32'h0001_0000);
      chk_rd("R5 summary bit written", A_STAT, 32'h1);
      chk("R7 irq after summary clear", {31'b0, irq_o}, 32'h0);
      wr(A_STAT, 32'h1);
      // summary set but its enable off
      wr(A_IEN, 32'h1);
      pulse(32'h1);
      chk_rd("R5 summary without its enable", A_STAT, 32'h0001_0001);
      chk("R7 irq masked by summary enable", {31'b0, irq_o}, 32'h0);
      wr(A_STAT, 32'h1);
      chk_rd("R5 cleanup", A_STAT, 32'h0);
   endtask

   task automatic t_abnormal;
      wr(A_IEN, 32'h0000_8010);
      pulse(32'h10);
      chk_rd("R6 abnormal summary set", A_STAT, 32'h0000_8010);
      chk("R7 irq from abnormal summary", {31'b0, irq_o}, 32'h1);
      pulse(32'h1);
      wr(A_STAT, 32'h1);
      chk_rd("R6 normal write keeps abnormal summary", A_STAT, 32'h0000_8010);
      chk("R6 irq kept", {31'b0, irq_o}, 32'h1);
      wr(A_STAT, 32'h10);
      chk_rd("R6 abnormal cleared", A_STAT, 32'h0);
      chk("R7 irq low", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_setwins;
      pulse(32'h1);
      wr_evt(A_STAT, 32'h1, 32'h1);
      chk_rd("R3 set beats clear", A_STAT, 32'h1);
      wr(A_STAT, 32'h1);
      chk_rd("R3 cleanup", A_STAT, 32'h0);
   endtask

   task automatic t_desc;
      wr(A_TXB, 32'h1000_0040);
      wr(A_RXB, 32'h2000_0080);
      wr(A_MAC, 32'h8);
      chk_rd("R9 tx descriptor loaded", A_CTX, 32'h1000_0040);
      chk_rd("R10 rx untouched by tx enable", A_CRX, 32'h0);
      wr(A_TXB, 32'h3000_0000);
      wr(A_MAC, 32'h8);
      chk_rd("R9 no reload while enabled", A_CTX, 32'h1000_0040);
      wr(A_MAC, 32'hC);
      chk_rd("R10 rx descriptor loaded", A_CRX, 32'h2000_0080);
      chk_rd("R10 tx untouched by rx enable", A_CTX, 32'h1000_0040);
      wr(A_MAC, 32'h0);
      wr(A_MAC, 32'h8);
      chk_rd("R9 reload on new rising edge", A_CTX, 32'h3000_0000);
      chk_rd("R1 mac config readback", A_MAC, 32'h8);
   endtask

   task automatic t_wo;
      wr(A_TXP, 32'hFFFF_FFFF);
      chk_rd("R11 tx poll reads zero", A_TXP, 32'h0);
      wr(A_RXP, 32'hFFFF_FFFF);
      chk_rd("R11 rx poll reads zero", A_RXP, 32'h0);
      wr(A_CTX, 32'h5555_5555);
      chk_rd("R11 current tx read-only", A_CTX, 32'h3000_0000);
   endtask

   task automatic t_swrst;
      wr(A_IEN, 32'h0001_0001);
      pulse(32'h1);
      chk("R8 irq before soft reset", {31'b0, irq_o}, 32'h1);
      wr(A_BUS, 32'h0000_0F01);
      chk("R8 irq after soft reset", {31'b0, irq_o}, 32'h0);
      chk_rd("R8 busmode reset value", A_BUS, 32'h100);
      chk_rd("R8 status cleared", A_STAT, 32'h0);
      chk_rd("R8 ien cleared", A_IEN, 32'h0);
      chk_rd("R8 tx base cleared", A_TXB, 32'h0);
      chk_rd("R8 current tx cleared", A_CTX, 32'h0);
      wr(A_BUS, 32'h0000_0F00);
      chk_rd("R8 busmode plain write", A_BUS, 32'h0000_0F00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_w1c;
      t_reject;
      t_normal;
      t_abnormal;
      t_setwins;
      t_desc;
      t_wo;
      t_swrst;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule